// File: doc/BRIEF.md
# Loop Requeue Stage Controller

This block sits directly in front of an execution unit's circular instruction queue and decides what enters it. Two sources compete for the queue's single write port. The loading port carries freshly delivered instructions. The recycle port carries instructions that have just left the queue's read end. Each instruction travels with a two-bit class tag that marks it as a loop opener, a loop closer or an ordinary instruction. The payload is never examined. It is only steered.

The stage has two modes. In the loading mode it fills the queue with new work and drops whatever is recycled, so the old loop body drains away. In the replay mode it shuts the loading port and feeds every recycled instruction back into the queue, so the loop body repeats. Entry into replay is a rendezvous. A loop closer waiting at the loading port and a loop opener waiting at the recycle port are swallowed together in one cycle, and the mode then changes. An executed abort returns the stage to the loading mode.

All handshakes are combinational valid/ready paths with no internal buffering. The only storage is the mode bit.

Top module: `loop_requeue`

## Requirements
- R1: After synchronous reset the stage is in the loading mode (`replay_mode` = 0), and with both inputs idle `dst_valid` is 0.
- R2: In the loading mode, a loading-port item whose class is not closer (class codes: 0 ordinary, 1 opener, 2 closer, 3 treated as ordinary) is presented on the output with its class and payload unchanged, and `ld_ready` equals `dst_ready`.
- R3: In the loading mode, a recycle-port item whose class is not opener is accepted (`rc_ready` = 1) whatever `dst_ready` is, and it never appears on the output.
- R4: In the loading mode, a closer on the loading port is held (`ld_ready` = 0) and not forwarded. While no opener waits on the recycle port, the mode does not change.
- R5: In the loading mode, an opener on the recycle port is held (`rc_ready` = 0) while no closer waits on the loading port. A non-closer on the loading port is still forwarded in the same cycle.
- R6: When a closer waits on the loading port and an opener waits on the recycle port in the loading mode, both are accepted in that cycle, nothing is output, and the stage is in the replay mode from the next cycle.
- R7: In the replay mode `ld_ready` is always 0.
- R8: In the replay mode every recycle-port item of any class is presented on the output with its class and payload, and `rc_ready` equals `dst_ready`.
- R9: A `loop_abort` pulse in the replay mode returns the stage to the loading mode on the next cycle. A recycle handshake in the same cycle still completes under replay rules.
- R10: A `loop_abort` pulse in the loading mode has no effect: the mode stays loading and a held closer stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Loading port item present |
| ld_kind | input | 2 | Loading port class tag |
| ld_data | input | DATA_W | Loading port payload |
| ld_ready | output | 1 | Loading port item accepted |
| rc_valid | input | 1 | Recycle port item present |
| rc_kind | input | 2 | Recycle port class tag |
| rc_data | input | DATA_W | Recycle port payload |
| rc_ready | output | 1 | Recycle port item accepted |
| dst_valid | output | 1 | Item offered to the queue |
| dst_kind | output | 2 | Class tag of offered item |
| dst_data | output | DATA_W | Payload of offered item |
| dst_ready | input | 1 | Queue can take the item |
| loop_abort | input | 1 | Executed abort pulse (after predication) |
| replay_mode | output | 1 | 1 while in the replay mode |

## Verification
The hardest situation to reach is an abort that lands in the same cycle as a recycle handshake. Its companion case is an abort while a closer is stuck in the loading mode. Both depend on the relative timing of three independent inputs. The directed scenarios first reach the replay mode through a real rendezvous. They then hold a recycled item on the port and assert the abort in that exact cycle, checking the handshake before the edge and the mode after it. A second scenario parks a closer at the loading port, pulses the abort and confirms the closer is still refused.

// File: rtl/loop_requeue_pkg.sv
package loop_requeue_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_OPENER = 2'd1,
        KIND_CLOSER = 2'd2,
        KIND_SPARE  = 2'd3
    } kind_e;

    typedef enum logic {
        MODE_LOAD   = 1'b0,
        MODE_REPLAY = 1'b1
    } mode_e;

    function automatic logic is_opener(input logic [KIND_W-1:0] k);
        return k == KIND_OPENER;
    endfunction

    function automatic logic is_closer(input logic [KIND_W-1:0] k);
        return k == KIND_CLOSER;
    endfunction

endpackage

// File: rtl/loop_requeue_mode.sv
module loop_requeue_mode
    import loop_requeue_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  join_fire,
    input  logic  loop_abort,
    output mode_e mode
);

    mode_e mode_q;
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LOAD:   if (join_fire)  mode_d = MODE_REPLAY;
            MODE_REPLAY: if (loop_abort) mode_d = MODE_LOAD;
            default:     mode_d = MODE_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_LOAD;
        else     mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R1: reset always lands in the loading mode
    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> mode == MODE_LOAD);

    // R9: an abort in replay ends the loop
    p_abort_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REPLAY && loop_abort) |=> mode == MODE_LOAD);

    // R10: an abort while loading changes nothing unless a rendezvous fires
    p_abort_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD && loop_abort && !join_fire) |=> mode == MODE_LOAD);

endmodule

// File: rtl/loop_requeue_steer.sv
module loop_requeue_steer
    import loop_requeue_pkg::*;
#(
    parameter int DATA_W = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              ld_valid,
    input  logic [KIND_W-1:0] ld_kind,
    input  logic [DATA_W-1:0] ld_data,
    output logic              ld_ready,
    input  logic              rc_valid,
    input  logic [KIND_W-1:0] rc_kind,
    input  logic [DATA_W-1:0] rc_data,
    output logic              rc_ready,
    output logic              dst_valid,
    output logic [KIND_W-1:0] dst_kind,
    output logic [DATA_W-1:0] dst_data,
    input  logic              dst_ready,
    output logic              join_fire
);

    logic ld_closer_wait;
    logic rc_opener_wait;

    assign ld_closer_wait = ld_valid && is_closer(ld_kind);
    assign rc_opener_wait = rc_valid && is_opener(rc_kind);

    always_comb begin
        ld_ready  = 1'b0;
        rc_ready  = 1'b0;
        dst_valid = 1'b0;
        dst_kind  = ld_kind;
        dst_data  = ld_data;
        join_fire = 1'b0;
        if (mode == MODE_REPLAY) begin
            dst_valid = rc_valid;
            dst_kind  = rc_kind;
            dst_data  = rc_data;
            rc_ready  = dst_ready;
        end else if (ld_closer_wait && rc_opener_wait) begin
            join_fire = 1'b1;
            ld_ready  = 1'b1;
            rc_ready  = 1'b1;
        end else begin
            if (ld_valid && !is_closer(ld_kind)) begin
                dst_valid = 1'b1;
                ld_ready  = dst_ready;
            end
            if (rc_valid && !is_opener(rc_kind)) begin
                rc_ready = 1'b1;
            end
        end
    end

    // R7: loading port shut during replay
    p_ld_shut_r7: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_REPLAY |-> !ld_ready);

    // R4: a closer is never offered to the queue while loading
    p_no_closer_out_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LOAD && dst_valid) |-> dst_kind != KIND_CLOSER);

    // R8: recycled item back-pressured by the queue in replay
    p_rc_backpress_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_REPLAY && rc_valid && !dst_ready) |-> !rc_ready);

    // R6: a rendezvous consumes both ports and offers nothing
    p_join_both_r6: assert property (@(posedge clk) disable iff (rst)
        join_fire |-> (ld_ready && rc_ready && !dst_valid));

endmodule

// File: rtl/loop_requeue.sv
module loop_requeue
    import loop_requeue_pkg::*;
#(
    parameter int DATA_W = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [1:0]        ld_kind,
    input  logic [DATA_W-1:0] ld_data,
    output logic              ld_ready,
    input  logic              rc_valid,
    input  logic [1:0]        rc_kind,
    input  logic [DATA_W-1:0] rc_data,
    output logic              rc_ready,
    output logic              dst_valid,
    output logic [1:0]        dst_kind,
    output logic [DATA_W-1:0] dst_data,
    input  logic              dst_ready,
    input  logic              loop_abort,
    output logic              replay_mode
);

    mode_e mode;
    logic  join_fire;

    loop_requeue_mode u_mode (
        .clk        (clk),
        .rst        (rst),
        .join_fire  (join_fire),
        .loop_abort (loop_abort),
        .mode       (mode)
    );

    loop_requeue_steer #(.DATA_W(DATA_W)) u_steer (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .ld_valid  (ld_valid),
        .ld_kind   (ld_kind),
        .ld_data   (ld_data),
        .ld_ready  (ld_ready),
        .rc_valid  (rc_valid),
        .rc_kind   (rc_kind),
        .rc_data   (rc_data),
        .rc_ready  (rc_ready),
        .dst_valid (dst_valid),
        .dst_kind  (dst_kind),
        .dst_data  (dst_data),
        .dst_ready (dst_ready),
        .join_fire (join_fire)
    );

    assign replay_mode = (mode == MODE_REPLAY);

    // R6: closer and opener meeting while loading starts replay
    p_enter_replay_r6: assert property (@(posedge clk) disable iff (rst)
        (!replay_mode && ld_valid && ld_kind == 2'd2 && rc_valid && rc_kind == 2'd1)
        |=> replay_mode);

    // R3: a non-opener recycled item is dropped while loading
    p_rc_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (!replay_mode && rc_valid && rc_kind != 2'd1) |-> rc_ready);

endmodule

// File: tb/loop_requeue_test.sv
module loop_requeue_test;

    localparam int DATA_W = 25;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_valid = 1'b0;
    logic [1:0]        ld_kind = 2'd0;
    logic [DATA_W-1:0] ld_data = '0;
    logic              ld_ready;
    logic              rc_valid = 1'b0;
    logic [1:0]        rc_kind = 2'd0;
    logic [DATA_W-1:0] rc_data = '0;
    logic              rc_ready;
    logic              dst_valid;
    logic [1:0]        dst_kind;
    logic [DATA_W-1:0] dst_data;
    logic              dst_ready = 1'b1;
    logic              loop_abort = 1'b0;
    logic              replay_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    loop_requeue #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_kind(ld_kind), .ld_data(ld_data), .ld_ready(ld_ready),
        .rc_valid(rc_valid), .rc_kind(rc_kind), .rc_data(rc_data), .rc_ready(rc_ready),
        .dst_valid(dst_valid), .dst_kind(dst_kind), .dst_data(dst_data), .dst_ready(dst_ready),
        .loop_abort(loop_abort), .replay_mode(replay_mode)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ld_valid = 0; rc_valid = 0; loop_abort = 0; dst_ready = 1;
        ld_kind = 0; rc_kind = 0;
    endtask

    // advance one edge; returns just after the following negedge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic enter_replay();
        ld_valid = 1; ld_kind = 2'd2; rc_valid = 1; rc_kind = 2'd1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        idle();
        rst = 1;
        tick(); tick();
        rst = 0;
        settle();
        chk("R1", "replay_mode", replay_mode, 0);
        chk("R1", "dst_valid", dst_valid, 0);
    endtask

    task automatic t_load_forward();
        ld_valid = 1; ld_kind = 2'd0; ld_data = 25'h1ABCDE; dst_ready = 1;
        settle();
        chk("R2", "dst_valid", dst_valid, 1);
        chk("R2", "dst_data", dst_data, 32'h1ABCDE);
        chk("R2", "ld_ready", ld_ready, 1);
        dst_ready = 0;
        settle();
        chk("R2", "ld_ready stall", ld_ready, 0);
        chk("R2", "dst_valid stall", dst_valid, 1);
        dst_ready = 1; ld_kind = 2'd1; ld_data = 25'h000777;
        settle();
        chk("R2", "opener kind", dst_kind, 2'd1);
        chk("R2", "opener data", dst_data, 32'h777);
        tick();
        idle();
    endtask

    task automatic t_load_drop();
        rc_valid = 1; rc_kind = 2'd0; rc_data = 25'h5555; dst_ready = 0;
        settle();
        chk("R3", "rc_ready", rc_ready, 1);
        chk("R3", "dst_valid", dst_valid, 0);
        rc_kind = 2'd2;
        settle();
        chk("R3", "closer dropped", rc_ready, 1);
        chk("R3", "closer not out", dst_valid, 0);
        tick();
        idle();
    endtask

    task automatic t_closer_hold();
        ld_valid = 1; ld_kind = 2'd2; ld_data = 25'h42;
        settle();
        chk("R4", "ld_ready", ld_ready, 0);
        chk("R4", "dst_valid", dst_valid, 0);
        tick(); tick();
        chk("R4", "mode", replay_mode, 0);
        chk("R4", "still held", ld_ready, 0);
        idle();
    endtask

    task automatic t_opener_hold();
        rc_valid = 1; rc_kind = 2'd1;
        settle();
        chk("R5", "rc_ready", rc_ready, 0);
        ld_valid = 1; ld_kind = 2'd0; ld_data = 25'h99;
        settle();
        chk("R5", "ld forwarded", dst_valid, 1);
        chk("R5", "ld_ready", ld_ready, 1);
        chk("R5", "rc still held", rc_ready, 0);
        tick();
        chk("R5", "mode", replay_mode, 0);
        idle();
    endtask

    task automatic t_rendezvous();
        ld_valid = 1; ld_kind = 2'd2; rc_valid = 1; rc_kind = 2'd1; dst_ready = 0;
        settle();
        chk("R6", "ld_ready", ld_ready, 1);
        chk("R6", "rc_ready", rc_ready, 1);
        chk("R6", "dst_valid", dst_valid, 0);
        tick();
        idle();
        chk("R6", "mode", replay_mode, 1);
    endtask

    task automatic t_replay();
        ld_valid = 1; ld_kind = 2'd0;
        settle();
        chk("R7", "ld_ready plain", ld_ready, 0);
        ld_kind = 2'd2;
        settle();
        chk("R7", "ld_ready closer", ld_ready, 0);
        ld_valid = 0;
        rc_valid = 1; rc_kind = 2'd1; rc_data = 25'h1000001;
        settle();
        chk("R8", "dst_valid", dst_valid, 1);
        chk("R8", "dst_kind", dst_kind, 2'd1);
        chk("R8", "dst_data", dst_data, 32'h1000001);
        chk("R8", "rc_ready", rc_ready, 1);
        dst_ready = 0;
        settle();
        chk("R8", "backpressure", rc_ready, 0);
        dst_ready = 1; rc_kind = 2'd2;
        settle();
        chk("R8", "closer passes", dst_kind, 2'd2);
        tick();
        chk("R8", "mode kept", replay_mode, 1);
        idle();
    endtask

    task automatic t_abort_exit();
        rc_valid = 1; rc_kind = 2'd0; rc_data = 25'h3C3C; loop_abort = 1;
        settle();
        chk("R9", "rc_ready", rc_ready, 1);
        chk("R9", "dst_valid", dst_valid, 1);
        chk("R9", "dst_data", dst_data, 32'h3C3C);
        tick();
        idle();
        chk("R9", "mode", replay_mode, 0);
    endtask

    task automatic t_abort_ignored();
        ld_valid = 1; ld_kind = 2'd2; loop_abort = 1;
        tick();
        loop_abort = 0;
        settle();
        chk("R10", "mode", replay_mode, 0);
        chk("R10", "closer held", ld_ready, 0);
        idle();
    endtask

    initial begin
        t_reset();
        t_load_forward();
        t_load_drop();
        t_closer_hold();
        t_opener_hold();
        t_rendezvous();
        t_replay();
        t_abort_exit();
        t_abort_ignored();
        enter_replay();
        chk("R6", "re-entry", replay_mode, 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule